// File: doc/BRIEF.md
# Context-Pointer Register Bank Addresser

This block turns a short register number into a RAM byte address inside the currently active register bank. A bank is sixteen consecutive 16-bit words, and its location is given only by a context pointer register. Moving to another bank takes a single write of a new pointer value. Several banks can sit in the same RAM at once, and only the one named by the pointer is reached. Three kinds of access are handled:

- word access to the sixteen word registers;
- byte access to sixteen byte registers, which alias the low and high halves of the first eight word registers;
- single-bit access to any bit of any word in the bank.

A small word RAM model sits behind the addresser so that reads, byte writes and bit-level read-modify-write updates can be checked from the ports. The address is produced combinationally in the cycle of the request. Read data comes back one clock later.

Top module: `ctxBankAddresser`

## Requirements
- R1: After reset the context pointer is 0, `rdValid` is 0 and every RAM word reads as 0.
- R2: A word access (`accKind` = 0, or the unused code 3) with index n addresses byte `base + 2*n`, drives `byteLane` = 2'b11, and `base` is the context pointer with bit 0 cleared.
- R3: A byte access (`accKind` = 1) with index i addresses byte `base + 2*(i>>1) + i[0]`. It drives `byteLane` = 2'b01 when i[0] = 0 (low half) and 2'b10 when i[0] = 1 (high half).
- R4: Bit 0 of a written context pointer value is ignored, so every bank starts on an even address.
- R5: A pointer written in one cycle governs accesses from the next cycle onward. An access in the same cycle as the write still uses the previous pointer.
- R6: A bit access (`accKind` = 2) with word index n and bit b addresses byte `base + 2*n`. It drives `bitSel` = 1<<b and `byteLane` = 2'b01 for b < 8 or 2'b10 for b >= 8. `bitSel` is 0 for other kinds.
- R7: A bit write sets bit b of the addressed word to `wrData[0]` and leaves the other 15 bits unchanged.
- R8: A byte write replaces only the addressed half of the word with `wrData[7:0]`. A byte read returns that half zero-extended in `rdData[7:0]`.
- R9: Every read request gives `rdValid` = 1 with its data in the next cycle. A bit read returns the bit in `rdData[0]` with the other bits 0. `rdValid` is 0 in a cycle that follows no read request.
- R10: Accesses through one context pointer leave the words of a bank at a non-overlapping pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpWrEn | input | 1 | Load a new context pointer |
| cpWrData | input | ADDR_W | New context pointer value |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accKind | input | 2 | 0 word, 1 byte, 2 bit, 3 treated as word |
| regIdx | input | 4 | Word register index or byte register index |
| bitIdx | input | 4 | Bit position for bit accesses |
| wrData | input | 16 | Write data (byte: [7:0], bit: [0]) |
| ramAddr | output | ADDR_W | Physical RAM byte address |
| byteLane | output | 2 | Byte lanes touched, bit 0 = low half |
| bitSel | output | 16 | One-hot bit selector for bit accesses |
| rdValid | output | 1 | Read data valid |
| rdData | output | 16 | Read data |

## Verification
A context pointer write and a register access can fall in the same cycle. The bench issues a word write together with a pointer load. It checks that the address seen in that cycle still comes from the old pointer and that the data landed in the old bank. The next access, and a read-back, must then land in the new bank. Bit and byte writes are judged through a byte-level shadow of the RAM that the bench keeps itself, and reads are compared in order by a scoreboard.

// File: rtl/cbaPkg.sv
package cbaPkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    KIND_WORD = 2'd0,
    KIND_BYTE = 2'd1,
    KIND_BIT  = 2'd2,
    KIND_RSV  = 2'd3
  } accKind_e;

  typedef struct packed {
    logic [3:0]        wordIdx;
    logic              hiByte;
    logic [1:0]        laneMask;
    logic [WORD_W-1:0] bitMask;
    logic              memWe;
    logic              rdEn;
    logic              bitOp;
    logic              byteOp;
  } bankStrobe_t;
endpackage

// File: rtl/cbaCtrl.sv
module cbaCtrl
  import cbaPkg::*;
(
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [1:0]  accKind,
  input  logic [3:0]  regIdx,
  input  logic [3:0]  bitIdx,
  output bankStrobe_t strb
);
  always_comb begin
    strb = '0;
    case (accKind_e'(accKind))
      KIND_BYTE: begin
        // byte register i aliases half of word register i>>1
        strb.wordIdx  = {1'b0, regIdx[3:1]};
        strb.hiByte   = regIdx[0];
        strb.laneMask = regIdx[0] ? 2'b10 : 2'b01;
        strb.byteOp   = 1'b1;
      end
      KIND_BIT: begin
        strb.wordIdx  = regIdx;
        strb.laneMask = bitIdx[3] ? 2'b10 : 2'b01;
        strb.bitMask  = WORD_W'(1) << bitIdx;
        strb.bitOp    = 1'b1;
      end
      default: begin
        strb.wordIdx  = regIdx;
        strb.laneMask = 2'b11;
      end
    endcase
    strb.memWe = accValid & accWrite;
    strb.rdEn  = accValid & ~accWrite;
  end
endmodule

// File: rtl/cbaDatapath.sv
module cbaDatapath
  import cbaPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpWrEn,
  input  logic [ADDR_W-1:0] cpWrData,
  input  logic [WORD_W-1:0] wrData,
  input  bankStrobe_t       strb,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [1:0]        byteLane,
  output logic [WORD_W-1:0] bitSel,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdData
);
  localparam int MEM_AW = $clog2(MEM_WORDS);

  logic [ADDR_W-1:0] cpReg;
  logic [WORD_W-1:0] mem [MEM_WORDS];
  logic [MEM_AW-1:0] memIdx;
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] newWord;
  logic [WORD_W-1:0] rdNext;

  // context pointer, forced even
  always_ff @(posedge clk) begin
    if (!rstN)       cpReg <= '0;
    else if (cpWrEn) cpReg <= cpWrData & ~ADDR_W'(1);
  end

  assign ramAddr  = cpReg + ADDR_W'({strb.wordIdx, 1'b0}) + ADDR_W'(strb.hiByte);
  assign byteLane = strb.laneMask;
  assign bitSel   = strb.bitMask;
  assign memIdx   = ramAddr[MEM_AW:1];
  assign curWord  = mem[memIdx];

  always_comb begin
    if (strb.bitOp)
      newWord = (curWord & ~strb.bitMask) | (wrData[0] ? strb.bitMask : '0);
    else if (strb.byteOp)
      newWord = strb.hiByte ? {wrData[7:0], curWord[7:0]} : {curWord[15:8], wrData[7:0]};
    else
      newWord = wrData;

    if (strb.bitOp)
      rdNext = {15'd0, |(curWord & strb.bitMask)};
    else if (strb.byteOp)
      rdNext = {8'd0, strb.hiByte ? curWord[15:8] : curWord[7:0]};
    else
      rdNext = curWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
    end else if (strb.memWe) begin
      mem[memIdx] <= newWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/ctxBankAddresser.sv
module ctxBankAddresser
  import cbaPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpWrEn,
  input  logic [ADDR_W-1:0] cpWrData,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [1:0]        accKind,
  input  logic [3:0]        regIdx,
  input  logic [3:0]        bitIdx,
  input  logic [15:0]       wrData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [1:0]        byteLane,
  output logic [15:0]       bitSel,
  output logic              rdValid,
  output logic [15:0]       rdData
);
  bankStrobe_t strb;

  cbaCtrl u_ctrl (
    .accValid(accValid),
    .accWrite(accWrite),
    .accKind (accKind),
    .regIdx  (regIdx),
    .bitIdx  (bitIdx),
    .strb    (strb)
  );

  cbaDatapath #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cpWrEn  (cpWrEn),
    .cpWrData(cpWrData),
    .wrData  (wrData),
    .strb    (strb),
    .ramAddr (ramAddr),
    .byteLane(byteLane),
    .bitSel  (bitSel),
    .rdValid (rdValid),
    .rdData  (rdData)
  );
endmodule

// File: rtl/cbaChecker.sv
module cbaChecker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpWrEn,
  input logic [ADDR_W-1:0] cpWrData,
  input logic              accValid,
  input logic              accWrite,
  input logic [1:0]        accKind,
  input logic [3:0]        regIdx,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [1:0]        byteLane,
  input logic [15:0]       bitSel,
  input logic              rdValid,
  input logic [15:0]       rdData
);
  logic rdReq;
  assign rdReq = accValid && !accWrite;

  a_r2_word_even: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accKind == 2'd0 || accKind == 2'd3)) |-> (ramAddr[0] == 1'b0 && byteLane == 2'b11));

  a_r3_byte_lane: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == 2'd1) |-> ($countones(byteLane) == 1 && byteLane[1] == ramAddr[0]));

  a_r6_bit_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accKind == 2'd2) |-> ($countones(bitSel) == 1 && ramAddr[0] == 1'b0));

  a_r5_cp_effect: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpWrEn) && accValid && accKind == 2'd0 && regIdx == 4'd0)
      |-> ramAddr == ($past(cpWrData) & ~ADDR_W'(1)));

  a_r9_rd_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  a_r8_byte_zext: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && accKind == 2'd1) |=> rdData < 16'd256);
endmodule

bind ctxBankAddresser cbaChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpWrEn  (cpWrEn),
  .cpWrData(cpWrData),
  .accValid(accValid),
  .accWrite(accWrite),
  .accKind (accKind),
  .regIdx  (regIdx),
  .ramAddr (ramAddr),
  .byteLane(byteLane),
  .bitSel  (bitSel),
  .rdValid (rdValid),
  .rdData  (rdData)
);

// File: tb/sim_ctxBankAddresser.sv
`timescale 1ns/1ps
module sim_ctxBankAddresser;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpWrEn = 1'b0;
  logic [15:0] cpWrData = '0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [1:0]  accKind = '0;
  logic [3:0]  regIdx = '0;
  logic [3:0]  bitIdx = '0;
  logic [15:0] wrData = '0;
  logic [15:0] ramAddr;
  logic [1:0]  byteLane;
  logic [15:0] bitSel;
  logic        rdValid;
  logic [15:0] rdData;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] tbCp = '0;
  logic [7:0]  sh [0:127];
  logic [15:0] expQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  ctxBankAddresser u0 (
    .clk(clk), .rstN(rstN), .cpWrEn(cpWrEn), .cpWrData(cpWrData),
    .accValid(accValid), .accWrite(accWrite), .accKind(accKind),
    .regIdx(regIdx), .bitIdx(bitIdx), .wrData(wrData),
    .ramAddr(ramAddr), .byteLane(byteLane), .bitSel(bitSel),
    .rdValid(rdValid), .rdData(rdData)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) chk("R9", "unexpected rdValid", 16'd1, 16'd0);
      else chk(tagQ.pop_front(), "rdData", rdData, expQ.pop_front());
    end
  end

  task automatic doAcc(input string tag, input logic [1:0] kind, input logic wr,
                       input logic [3:0] idx, input logic [3:0] bi, input logic [15:0] d,
                       input logic cpW = 1'b0, input logic [15:0] cpV = 16'd0);
    logic [15:0] a;
    logic [15:0] w;
    logic [6:0]  lo;
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accKind = kind; regIdx = idx; bitIdx = bi;
    wrData = d; cpWrEn = cpW; cpWrData = cpV;
    if (kind == 2'd1) a = {tbCp[15:1], 1'b0} + 16'({idx[3:1], 1'b0}) + 16'(idx[0]);
    else              a = {tbCp[15:1], 1'b0} + 16'({idx, 1'b0});
    #1;
    chk(tag, "ramAddr", ramAddr, a);
    if (kind == 2'd1) chk(tag, "byteLane", 16'(byteLane), idx[0] ? 16'd2 : 16'd1);
    else if (kind == 2'd2) begin
      chk(tag, "bitSel", bitSel, 16'd1 << bi);
      chk(tag, "byteLane", 16'(byteLane), bi[3] ? 16'd2 : 16'd1);
    end else begin
      chk(tag, "byteLane", 16'(byteLane), 16'd3);
      chk(tag, "bitSel", bitSel, 16'd0);
    end
    lo = {a[6:1], 1'b0};
    w = {sh[lo + 7'd1], sh[lo]};
    if (wr) begin
      if (kind == 2'd1) sh[a[6:0]] = d[7:0];
      else begin
        if (kind == 2'd2) w[bi] = d[0];
        else w = d;
        sh[lo] = w[7:0];
        sh[lo + 7'd1] = w[15:8];
      end
    end else begin
      if (kind == 2'd1)      expQ.push_back({8'd0, sh[a[6:0]]});
      else if (kind == 2'd2) expQ.push_back({15'd0, w[bi]});
      else                   expQ.push_back(w);
      tagQ.push_back(tag);
    end
    @(posedge clk);
    if (cpW) tbCp = {cpV[15:1], 1'b0};
  endtask

  task automatic setCp(input logic [15:0] v);
    @(negedge clk);
    accValid = 1'b0; cpWrEn = 1'b1; cpWrData = v;
    @(posedge clk);
    tbCp = {v[15:1], 1'b0};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accValid = 1'b0; cpWrEn = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 128; i++) sh[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "rdValid in reset", 16'(rdValid), 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "rdValid after reset", 16'(rdValid), 16'd0);
    doAcc("R1", 2'd0, 1'b0, 4'd0, 4'd0, 16'd0);
    doAcc("R1", 2'd0, 1'b0, 4'd15, 4'd0, 16'd0);

    // R2: word bank at 0x20
    setCp(16'h0020);
    for (int n = 0; n < 16; n++) doAcc("R2", 2'd0, 1'b1, 4'(n), 4'd0, 16'hA000 + 16'(n) * 16'h0111);
    for (int n = 0; n < 16; n += 5) doAcc("R2", 2'd0, 1'b0, 4'(n), 4'd0, 16'd0);
    doAcc("R2", 2'd3, 1'b0, 4'd7, 4'd0, 16'd0);

    // R3: every byte register
    for (int i = 0; i < 16; i++) doAcc("R3", 2'd1, 1'b0, 4'(i), 4'd0, 16'd0);

    // R8: byte writes touch one half only
    doAcc("R8", 2'd1, 1'b1, 4'd7, 4'd0, 16'hFF5C);
    doAcc("R8", 2'd1, 1'b1, 4'd8, 4'd0, 16'h1234);
    doAcc("R8", 2'd0, 1'b0, 4'd3, 4'd0, 16'd0);
    doAcc("R8", 2'd0, 1'b0, 4'd4, 4'd0, 16'd0);
    doAcc("R8", 2'd1, 1'b0, 4'd7, 4'd0, 16'd0);

    // R6 / R7: bit accesses with read-modify-write
    doAcc("R7", 2'd2, 1'b1, 4'd5, 4'd13, 16'h0001);
    doAcc("R7", 2'd2, 1'b1, 4'd5, 4'd0, 16'hFFFE);
    doAcc("R7", 2'd0, 1'b0, 4'd5, 4'd0, 16'd0);
    doAcc("R6", 2'd2, 1'b0, 4'd5, 4'd13, 16'd0);
    doAcc("R6", 2'd2, 1'b0, 4'd5, 4'd0, 16'd0);
    doAcc("R6", 2'd2, 1'b0, 4'd9, 4'd3, 16'd0);
    doAcc("R7", 2'd2, 1'b1, 4'd15, 4'd15, 16'h0000);
    doAcc("R7", 2'd0, 1'b0, 4'd15, 4'd0, 16'd0);

    // R4: odd pointer is rounded down
    setCp(16'h0041);
    doAcc("R4", 2'd0, 1'b1, 4'd2, 4'd0, 16'hBEEF);
    doAcc("R4", 2'd1, 1'b0, 4'd5, 4'd0, 16'd0);
    doAcc("R4", 2'd0, 1'b0, 4'd2, 4'd0, 16'd0);

    // R10: first bank unchanged
    setCp(16'h0020);
    for (int n = 0; n < 16; n++) doAcc("R10", 2'd0, 1'b0, 4'(n), 4'd0, 16'd0);

    // R5: pointer write and access in the same cycle
    doAcc("R5", 2'd0, 1'b1, 4'd0, 4'd0, 16'hC0DE, 1'b1, 16'h0060);
    doAcc("R5", 2'd0, 1'b0, 4'd0, 4'd0, 16'd0);
    doAcc("R5", 2'd0, 1'b1, 4'd1, 4'd0, 16'h7E57);
    setCp(16'h0020);
    doAcc("R5", 2'd0, 1'b0, 4'd0, 4'd0, 16'd0);
    doAcc("R5", 2'd0, 1'b0, 4'd1, 4'd0, 16'd0, 1'b1, 16'h0060);
    doAcc("R5", 2'd0, 1'b0, 4'd1, 4'd0, 16'd0);

    idle(4);
    chk("R9", "pending reads", 16'(expQ.size()), 16'd0);
    chk("R9", "rdValid idle", 16'(rdValid), 16'd0);
    finishRun();
  end
endmodule